// File: doc/BRIEF.md
# Thirty-Two Channel Hysteresis Threshold Detector with SPI Register Slave

This block is the digital core of a discrete-input monitor. Every channel takes a voltage code in whole volts and turns it into a one-bit state through a comparator with hysteresis. The state sets when the code reaches the upper level, clears when the code falls to the lower level, and holds in between. The levels come from two threshold registers, one for ground-open sensing and one for supply-open sensing. Each register holds the hysteresis and the doubled centre value. A sense-mode register picks, for each bank of eight channels, which of the two registers applies.

A host reaches the registers over an SPI slave port (mode 0, active-low select). The SPI pins are oversampled in the system clock domain. The first byte of each frame is the command. Its bit 7 set means read and clear means write, and bits 6:0 hold the register address. Data bytes follow, most significant first. The host can read channel states one bank at a time as a byte, or all at once as one word.

An odd hysteresis value puts the device into a lock state, in which channel states freeze. A software reset through the control register leaves that state, and so does the hardware reset.

Top module: `thresh_bank_spi`

## Requirements
- R1: The first frame byte is the command: bit 7 = 1 means read, bit 7 = 0 means write, and bits 6:0 are the address. Data bits are sampled on SCLK rising edges. On a read, data is shifted out MSB first, starting with the first SCLK cycle after the command byte.
- R2: A read of an unmapped address returns zeros. A write to an unmapped address changes no register.
- R3: Control register 0x02 (1 byte). Bit 0 is a stored test flag with no other effect. While bit 1 is set, the device is held in soft reset: sense mode reads 0, both threshold registers read 0x0206, all channel states are 0, and the lock is cleared. Writing 0x00 afterwards resumes normal operation.
- R4: Sense register 0x04 (1 byte). Bit n selects the register for channels 8n..8n+7: 0 selects the ground-open register, 1 selects the supply-open register. Bits 7:4 read as 0.
- R5: Threshold registers 0x3A (ground-open) and 0x3C (supply-open) are 16 bits wide. The upper byte is the hysteresis and the lower byte is the sum of the high and low levels. Both reset to 0x0206.
- R6: Each channel uses high = (sum+hyst)/2 and low = (sum-hyst)/2. The next clock sets the state if the code is at or above high. Otherwise it clears the state if the code is at or below low, and otherwise holds it.
- R7: A 4-byte read of 0x78 returns channels 31..0, MSB first. One-byte reads of 0x10, 0x12, 0x14 and 0x16 return channels 7:0, 15:8, 23:16 and 31:23+1 respectively, with the highest channel in bit 7.
- R8: Writing a threshold register with an odd hysteresis stores the value and sets a lock. While locked, channel states do not change, until a soft or hardware reset.
- R9: A write takes effect only when the last bit of its final data byte is received. A frame ended by chip select in the middle of a byte, or before all bytes of a 16-bit write, changes nothing.
- R10: rst_n is active low and clears asynchronously; its release is synchronized. Reset clears all registers to their reset values and all channel states to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock (mode 0) |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | SPI data from host |
| miso | output | 1 | SPI data to host |
| ch_level | input | NCH*VW | Per-channel voltage codes, channel c at bits c*VW +: VW |
| ch_state | output | NCH | Per-channel comparator states |

## Verification
The bench walks a channel code across both levels in each direction. A comparator that used a strict compare, or that cleared in the hysteresis band, would show a wrong state at exactly the codes 4 and 3. Mixed sense-mode banks run with the code placed in one register's band and above the other's, so a wrong bank-to-bit mapping lights the wrong byte. Frames are cut short in the middle of a byte and between the bytes of a 16-bit write; a slave that commits on partial data would corrupt a threshold. The lock test writes an odd hysteresis and raises every code. A design that ignored the lock would show states rising, and one whose soft reset missed a register would read back a stale value.

// File: rtl/thresh_bank_spi.sv
module thresh_bank_spi #(
  parameter int NCH = 32,
  parameter int VW  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  input  logic [NCH*VW-1:0] ch_level,
  output logic [NCH-1:0]    ch_state
);
  localparam int NBANK = NCH / 8;
  localparam logic [6:0] A_CTRL  = 7'h02;
  localparam logic [6:0] A_SENSE = 7'h04;
  localparam logic [6:0] A_STAT  = 7'h10;
  localparam logic [6:0] A_GND   = 7'h3A;
  localparam logic [6:0] A_SUP   = 7'h3C;
  localparam logic [6:0] A_WORD  = 7'h78;
  localparam logic [15:0] THR_RST = 16'h0206;

  logic [1:0] rst_q;
  logic       arst_n;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  assign arst_n = rst_q[1];

  logic [2:0] sck_q, csn_q;
  logic [1:0] mosi_q;
  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) begin
      sck_q  <= 3'b000;
      csn_q  <= 3'b111;
      mosi_q <= 2'b00;
    end else begin
      sck_q  <= {sck_q[1:0], sclk};
      csn_q  <= {csn_q[1:0], cs_n};
      mosi_q <= {mosi_q[0], mosi};
    end

  logic sel, rise, fall;
  assign sel  = !csn_q[1];
  assign rise = sel && sck_q[1] && !sck_q[2];
  assign fall = sel && !sck_q[1] && sck_q[2];

  logic [5:0]     cnt;
  logic [7:0]     cmd, rxb, hold1;
  logic [7:0]     rx_next;
  logic [NCH-1:0] tx, rd_word;
  logic [1:0]     ctrl;
  logic [NBANK-1:0] sense;
  logic [15:0]    thr_g, thr_s;
  logic           locked;

  assign rx_next = {rxb[6:0], mosi_q[1]};
  assign miso    = tx[NCH-1];

  always_comb begin
    rd_word = '0;
    case (rx_next[6:0])
      A_CTRL:  rd_word[NCH-1 -: 8]  = {6'b0, ctrl};
      A_SENSE: rd_word[NCH-1 -: 8]  = 8'(sense);
      A_GND:   rd_word[NCH-1 -: 16] = thr_g;
      A_SUP:   rd_word[NCH-1 -: 16] = thr_s;
      A_WORD:  rd_word              = ch_state;
      default: ;
    endcase
    for (int k = 0; k < NBANK; k++)
      if (rx_next[6:0] == 7'(int'(A_STAT) + 2 * k))
        rd_word[NCH-1 -: 8] = ch_state[8*k +: 8];
  end

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) begin
      cnt   <= '0;
      cmd   <= '0;
      rxb   <= '0;
      hold1 <= '0;
      tx    <= '0;
    end else if (!sel) begin
      cnt <= '0;
      tx  <= '0;
    end else if (rise) begin
      rxb <= rx_next;
      if (cnt != 6'd63) cnt <= cnt + 6'd1;
      if (cnt == 6'd7) begin
        cmd <= rx_next;
        tx  <= rx_next[7] ? rd_word : '0;
      end
      if (cnt == 6'd15) hold1 <= rx_next;
    end else if (fall && cnt > 6'd8) begin
      tx <= {tx[NCH-2:0], 1'b0};
    end

  logic        wr8, wr16, wr_ctrl, wr_sense, wr_g, wr_s, srst;
  logic [15:0] wdat16;
  assign wr8      = rise && cnt == 6'd15 && !cmd[7];
  assign wr16     = rise && cnt == 6'd23 && !cmd[7];
  assign wr_ctrl  = wr8  && cmd[6:0] == A_CTRL;
  assign wr_sense = wr8  && cmd[6:0] == A_SENSE;
  assign wr_g     = wr16 && cmd[6:0] == A_GND;
  assign wr_s     = wr16 && cmd[6:0] == A_SUP;
  assign wdat16   = {hold1, rx_next};
  assign srst     = ctrl[1] || (wr_ctrl && rx_next[1]);

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) begin
      ctrl   <= '0;
      sense  <= '0;
      thr_g  <= THR_RST;
      thr_s  <= THR_RST;
      locked <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= rx_next[1:0];
      if (srst) begin
        sense  <= '0;
        thr_g  <= THR_RST;
        thr_s  <= THR_RST;
        locked <= 1'b0;
      end else begin
        if (wr_sense) sense <= rx_next[NBANK-1:0];
        if (wr_g) thr_g <= wdat16;
        if (wr_s) thr_s <= wdat16;
        if ((wr_g || wr_s) && wdat16[8]) locked <= 1'b1;
      end
    end

  function automatic logic [8:0] lvl_hi(input logic [15:0] r);
    return 9'(({1'b0, r[7:0]} + {1'b0, r[15:8]}) >> 1);
  endfunction
  function automatic logic [8:0] lvl_lo(input logic [15:0] r);
    return (r[7:0] >= r[15:8]) ? 9'((r[7:0] - r[15:8]) >> 1) : 9'd0;
  endfunction

  logic [8:0] hi_g, lo_g, hi_s, lo_s, hi0, lo0;
  assign hi_g = lvl_hi(thr_g);
  assign lo_g = lvl_lo(thr_g);
  assign hi_s = lvl_hi(thr_s);
  assign lo_s = lvl_lo(thr_s);
  assign hi0  = sense[0] ? hi_s : hi_g;
  assign lo0  = sense[0] ? lo_s : lo_g;

  logic [NCH-1:0] nxt;
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [8:0] lv, hi, lo;
    assign lv = 9'(ch_level[c*VW +: VW]);
    assign hi = sense[c/8] ? hi_s : hi_g;
    assign lo = sense[c/8] ? lo_s : lo_g;
    assign nxt[c] = (lv >= hi) ? 1'b1 : (lv <= lo) ? 1'b0 : ch_state[c];
  end

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n)      ch_state <= '0;
    else if (srst)    ch_state <= '0;
    else if (!locked) ch_state <= nxt;
endmodule

// File: rtl/thresh_bank_spi_chk.sv
module thresh_bank_spi_chk #(
  parameter int NCH = 32,
  parameter int VW  = 5
) (
  input logic           clk,
  input logic           arst_n,
  input logic           locked,
  input logic           srst,
  input logic [NCH-1:0] ch_state,
  input logic [VW-1:0]  lvl0,
  input logic [8:0]     hi0,
  input logic [8:0]     lo0,
  input logic [5:0]     cnt,
  input logic           miso
);
  logic [8:0] lv0;
  assign lv0 = 9'(lvl0);

  p_ch_set_r6: assert property (@(posedge clk) disable iff (!arst_n)
    !srst && $past(!locked && !srst && lv0 >= hi0) |-> ch_state[0]);
  p_ch_clear_r6: assert property (@(posedge clk) disable iff (!arst_n)
    !srst && $past(!locked && !srst && lv0 < hi0 && lv0 <= lo0) |-> !ch_state[0]);
  p_ch_hold_r6: assert property (@(posedge clk) disable iff (!arst_n)
    !srst && $past(!locked && !srst && lv0 < hi0 && lv0 > lo0) |-> $stable(ch_state[0]));
  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!arst_n)
    locked && !srst |=> locked || srst);
  p_lock_freeze_r8: assert property (@(posedge clk) disable iff (!arst_n)
    locked && $past(locked) |-> $stable(ch_state));
  p_srst_clear_r3: assert property (@(posedge clk) disable iff (!arst_n)
    srst |=> ch_state == '0 && !locked);
  p_miso_cmd_r1: assert property (@(posedge clk) disable iff (!arst_n)
    cnt < 6'd8 |-> !miso);
endmodule

bind thresh_bank_spi thresh_bank_spi_chk #(.NCH(NCH), .VW(VW)) chk_i (
  .clk(clk), .arst_n(arst_n), .locked(locked), .srst(ctrl[1]),
  .ch_state(ch_state), .lvl0(ch_level[VW-1:0]), .hi0(hi0), .lo0(lo0),
  .cnt(cnt), .miso(miso)
);

// File: tb/thresh_bank_spi_tb_top.sv
module thresh_bank_spi_tb_top;
  localparam int NCH = 32;
  localparam int VW = 5;
  localparam int HALF = 6;

  logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, mosi = 0;
  logic miso;
  logic [NCH*VW-1:0] ch_level = '0;
  logic [NCH-1:0] ch_state;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  thresh_bank_spi #(.NCH(NCH), .VW(VW)) dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .ch_level(ch_level), .ch_state(ch_state));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [7:0] c, input int nbytes, input logic [31:0] wd,
                       input int stop_bits, output logic [31:0] rd);
    int nb;
    nb = (stop_bits >= 0) ? stop_bits : 8 + 8 * nbytes;
    rd = '0;
    @(negedge clk); cs_n = 0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      mosi = (i < 8) ? c[7-i] : wd[nbytes*8-1-(i-8)];
      repeat (HALF) @(negedge clk);
      if (i >= 8) rd = {rd[30:0], miso};
      sclk = 1;
      repeat (HALF) @(negedge clk);
      sclk = 0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1; mosi = 0;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic wr8(input logic [6:0] a, input logic [7:0] v);
    logic [31:0] d;
    frame({1'b0, a}, 1, 32'(v), -1, d);
  endtask
  task automatic wr16(input logic [6:0] a, input logic [15:0] v);
    logic [31:0] d;
    frame({1'b0, a}, 2, 32'(v), -1, d);
  endtask
  task automatic rd(input logic [6:0] a, input int n, output logic [31:0] v);
    frame({1'b1, a}, n, 32'h0, -1, v);
  endtask

  task automatic set_all(input int v);
    for (int c = 0; c < NCH; c++) ch_level[c*VW +: VW] = VW'(v);
    repeat (4) @(negedge clk);
  endtask
  task automatic set_ch0(input int v);
    ch_level[VW-1:0] = VW'(v);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset_state;
    logic [31:0] v;
    check("R10 state after reset", 32'(ch_state), 32'h0);
    rd(7'h3A, 2, v); check("R5 R1 gnd reg reset", v, 32'h0206);
    rd(7'h3C, 2, v); check("R5 sup reg reset", v, 32'h0206);
    rd(7'h02, 1, v); check("R3 ctrl reset", v, 32'h0);
    rd(7'h04, 1, v); check("R4 sense reset", v, 32'h0);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    rd(7'h20, 1, v); check("R2 unmapped byte", v, 32'h0);
    rd(7'h7F, 4, v); check("R2 unmapped word", v, 32'h0);
    wr8(7'h20, 8'hFF);
    rd(7'h04, 1, v); check("R2 write unmapped sense", v, 32'h0);
    rd(7'h3A, 2, v); check("R2 write unmapped thr", v, 32'h0206);
  endtask

  task automatic t_compare;
    set_all(0);
    set_ch0(5); check("R6 above high sets", 32'(ch_state[0]), 32'h1);
    set_ch0(4); check("R6 at high stays set", 32'(ch_state[0]), 32'h1);
    set_ch0(3); check("R6 band holds set", 32'(ch_state[0]), 32'h1);
    set_ch0(2); check("R6 at low clears", 32'(ch_state[0]), 32'h0);
    set_ch0(3); check("R6 band holds clear", 32'(ch_state[0]), 32'h0);
    set_ch0(4); check("R6 at high sets", 32'(ch_state[0]), 32'h1);
  endtask

  task automatic t_status;
    logic [31:0] v, exp;
    exp = '0;
    for (int c = 0; c < NCH; c++) begin
      ch_level[c*VW +: VW] = (c % 3 == 0) ? VW'(10) : VW'(0);
      exp[c] = (c % 3 == 0);
    end
    repeat (4) @(negedge clk);
    rd(7'h78, 4, v); check("R7 word read", v, exp);
    for (int k = 0; k < 4; k++) begin
      rd(7'(7'h10 + 2 * k), 1, v);
      check("R7 bank byte read", v, 32'(exp[8*k +: 8]));
    end
  endtask

  task automatic t_sense;
    logic [31:0] v;
    set_all(0);
    wr16(7'h3C, 16'h0214);
    wr8(7'h04, 8'h02);
    rd(7'h04, 1, v); check("R4 sense readback", v, 32'h02);
    set_all(10); check("R4 bank1 in band", 32'(ch_state), 32'hFFFF00FF);
    set_all(11); check("R4 bank1 at high", 32'(ch_state), 32'hFFFFFFFF);
    set_all(9);  check("R4 bank1 at low", 32'(ch_state), 32'hFFFF00FF);
    wr8(7'h04, 8'hFF);
    rd(7'h04, 1, v); check("R4 upper bits zero", v, 32'h0F);
    wr8(7'h04, 8'h00);
  endtask

  task automatic t_abort;
    logic [31:0] v;
    frame(8'h3A, 2, 32'h0408, 20, v);
    rd(7'h3A, 2, v); check("R9 partial 16-bit write", v, 32'h0206);
    frame(8'h04, 1, 32'h0F, 13, v);
    rd(7'h04, 1, v); check("R9 mid-byte abort", v, 32'h0);
    frame(8'h04, 1, 32'h0F, 3, v);
    rd(7'h3A, 2, v); check("R9 abort in command byte", v, 32'h0206);
  endtask

  task automatic t_ctrl_test;
    logic [31:0] v;
    set_all(0);
    wr8(7'h02, 8'h01);
    rd(7'h02, 1, v); check("R3 test flag stored", v, 32'h01);
    set_all(6); check("R3 test flag no effect", 32'(ch_state), 32'hFFFFFFFF);
    wr8(7'h02, 8'h00);
  endtask

  task automatic t_lock;
    logic [31:0] v;
    set_all(0);
    check("R8 pre-lock clear", 32'(ch_state), 32'h0);
    wr16(7'h3A, 16'h0306);
    rd(7'h3A, 2, v); check("R8 odd value stored", v, 32'h0306);
    set_all(20);
    check("R8 locked freezes port", 32'(ch_state), 32'h0);
    rd(7'h78, 4, v); check("R8 locked freezes word", v, 32'h0);
    wr8(7'h02, 8'h02);
    rd(7'h02, 1, v); check("R3 soft reset flag", v, 32'h02);
    check("R3 soft reset states", 32'(ch_state), 32'h0);
    rd(7'h3A, 2, v); check("R3 soft reset gnd reg", v, 32'h0206);
    rd(7'h3C, 2, v); check("R3 soft reset sup reg", v, 32'h0206);
    wr8(7'h02, 8'h00);
    repeat (4) @(negedge clk);
    check("R3 resume after release", 32'(ch_state), 32'hFFFFFFFF);
  endtask

  task automatic t_hwreset;
    logic [31:0] v;
    wr8(7'h04, 8'h05);
    wr16(7'h3C, 16'h0A10);
    #3 rst_n = 0;
    #2 check("R10 async clear", 32'(ch_state), 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    set_all(0);
    rd(7'h04, 1, v); check("R10 sense cleared", v, 32'h0);
    rd(7'h3C, 2, v); check("R10 sup reg reset", v, 32'h0206);
  endtask

  initial begin : wdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    t_reset_state;
    t_unmapped;
    t_compare;
    t_status;
    t_sense;
    t_abort;
    t_ctrl_test;
    t_lock;
    t_hwreset;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule